// File: doc/BRIEF.md
# Serial audio link reset and wake sequencer

This block sits on the controller side of a serial audio codec link. It handles resets and power-down recovery. A software cold-reset control bit drives the active-low codec reset line directly. A software warm-reset request wakes the link by driving SYNC. When the bit clock from the codec is missing, that wake is a timed high pulse on SYNC, measured in system-clock cycles.

The block runs on a free-running system clock. It synchronises the codec bit clock and watches it with a watchdog, and it tracks the bit position inside each 256-bit frame. It takes the codec-ready tag from the first bit of every incoming frame.

After a power-down request, the block waits for the current frame to close. It then waits four more frame times before any SYNC wake pulse may start, and a warm request made meanwhile is held pending. A busy flag covers every reset, wait and pulse.

Top module: `aclink_wake_seq`

## Requirements
- R1: `codec_rst_no` is 0 during system reset and follows `cold_ctl_i` one system clock later; it is 0 whenever the cold-reset control has been 0 for a cycle.
- R2: While `cold_ctl_i` is 0, the pending warm bit, the ready flag and any power-down wait are cleared, and `warm_set_i` pulses are ignored; after release, no SYNC pulse follows from them.
- R3: A warm request (`warm_set_i` pulse sets `warm_bit_o` to 1) made while the bit clock is absent drives `sync_o` high for exactly SYNC_CYC system clocks (default 50), then low. `warm_bit_o` clears when the pulse ends.
- R4: A warm request made while the bit clock is present produces no SYNC pulse, and `warm_bit_o` clears within two system clocks.
- R5: `bitclk_alive_o` is 0 after reset. It becomes 1 shortly after a synchronised rising edge of `bitclk_i`, and returns to 0 once WD_CYC (16) system clocks pass with no rising edge.
- R6: Frame position 0 is the first bit after the first rising edge that follows a period with the bit clock absent. A frame is 256 bit clocks. On the falling edge after each frame's first rising edge, `sdata_i` is sampled as the ready tag, and `ready_o` takes that value (1 sets it, 0 clears it). A power-down request also clears `ready_o`.
- R7: After a `pdown_i` pulse, no SYNC pulse starts until the current frame ends (or the bit clock is lost) and then 1024 bit times (four frames) pass. Bit times are counted on bit-clock edges, or every BIT_SYS (4) system clocks while the clock is absent. A warm request held during this wait starts its SYNC pulse once the wait ends.
- R8: `busy_o` is 1 while cold reset is requested, during a power-down wait, or while a warm request is pending or its pulse runs; otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running system clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cold_ctl_i | input | 1 | Cold-reset control bit, 0 requests codec reset |
| warm_set_i | input | 1 | One-cycle pulse setting the warm-reset bit |
| pdown_i | input | 1 | One-cycle pulse marking link power-down |
| bitclk_i | input | 1 | Codec bit clock, asynchronous |
| sdata_i | input | 1 | Serial data from the codec |
| codec_rst_no | output | 1 | Active-low codec reset |
| sync_o | output | 1 | SYNC wake pulse |
| warm_bit_o | output | 1 | Warm-reset bit, self-clearing |
| ready_o | output | 1 | Codec ready from the frame tag |
| busy_o | output | 1 | Reset or wait sequence in progress |
| bitclk_alive_o | output | 1 | Bit clock currently detected |

## Verification
The bench makes a warm request during a power-down wait and stops the bit clock exactly at the end of the frame. SYNC must then stay low for at least four frame times. A design that counted from the request, or stalled its count when the clock stopped, would pulse too early or never.

It measures the SYNC pulse width to the cycle. It also checks that no pulse appears when the bit clock is running, which catches a design that stretched SYNC while codec clocks could arrive.

It drops the cold control in the middle of a wait and checks that the pending warm request is discarded rather than replayed. It restarts the bit clock and checks that the ready tag is taken from frame bit 0, not from a stale position.

// File: rtl/aclink_wake_pkg.sv
package aclink_wake_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PD_FRAME,
    ST_PD_WAIT,
    ST_SYNC
  } seq_state_e;
endpackage

// File: rtl/aclink_bclk_mon.sv
module aclink_bclk_mon #(
  parameter int SYNC_STAGES = 2,
  parameter int WD_CYC      = 16,
  parameter int BIT_SYS     = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bitclk_i,
  input  logic sdata_i,
  output logic rise_o,
  output logic fall_o,
  output logic sdata_o,
  output logic alive_o,
  output logic tick_o
);
  localparam int WDW = $clog2(WD_CYC + 1);
  localparam int PSW = (BIT_SYS > 2) ? $clog2(BIT_SYS) : 1;

  logic [SYNC_STAGES-1:0] clk_sync, dat_sync;
  logic                   clk_d;
  logic [WDW-1:0]         wd_cnt;
  logic [PSW-1:0]         ps_cnt;
  logic                   clk_s, ps_wrap;

  assign clk_s   = clk_sync[SYNC_STAGES-1];
  assign sdata_o = dat_sync[SYNC_STAGES-1];
  assign rise_o  = clk_s & ~clk_d;
  assign fall_o  = ~clk_s & clk_d;
  assign alive_o = (wd_cnt != WDW'(WD_CYC));
  assign ps_wrap = (ps_cnt == PSW'(BIT_SYS - 1));
  // nominal bit time while the codec clock is gone
  assign tick_o  = alive_o ? rise_o : ps_wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_sync <= '0;
      dat_sync <= '0;
      clk_d    <= 1'b0;
      wd_cnt   <= WDW'(WD_CYC);
      ps_cnt   <= '0;
    end else begin
      clk_sync <= {clk_sync[SYNC_STAGES-2:0], bitclk_i};
      dat_sync <= {dat_sync[SYNC_STAGES-2:0], sdata_i};
      clk_d    <= clk_s;
      if (rise_o)        wd_cnt <= '0;
      else if (alive_o)  wd_cnt <= wd_cnt + 1'b1;
      if (alive_o || ps_wrap) ps_cnt <= '0;
      else                    ps_cnt <= ps_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/aclink_frame_pos.sv
module aclink_frame_pos #(
  parameter int FRAME_BITS = 256,
  localparam int PW = $clog2(FRAME_BITS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hold_i,
  input  logic          rise_i,
  input  logic          alive_i,
  output logic [PW-1:0] pos_o,
  output logic          frame_end_o
);
  logic at_last;
  assign at_last     = (pos_o == PW'(FRAME_BITS - 1));
  assign frame_end_o = rise_i & at_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         pos_o <= '0;
    else if (hold_i)     pos_o <= '0;
    else if (rise_i)     pos_o <= at_last ? '0 : pos_o + 1'b1;
    else if (!alive_i)   pos_o <= '0;
  end
endmodule

// File: rtl/aclink_wake_seq.sv
module aclink_wake_seq
  import aclink_wake_pkg::*;
#(
  parameter int SYNC_CYC    = 50,
  parameter int FRAME_BITS  = 256,
  parameter int WAIT_FRAMES = 4,
  parameter int WD_CYC      = 16,
  parameter int BIT_SYS     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cold_ctl_i,
  input  logic warm_set_i,
  input  logic pdown_i,
  input  logic bitclk_i,
  input  logic sdata_i,
  output logic codec_rst_no,
  output logic sync_o,
  output logic warm_bit_o,
  output logic ready_o,
  output logic busy_o,
  output logic bitclk_alive_o
);
  localparam int WAIT_BITS = FRAME_BITS * WAIT_FRAMES;
  localparam int WW = $clog2(WAIT_BITS);
  localparam int SW = $clog2(SYNC_CYC);
  localparam int CW = (WW > SW) ? WW : SW;
  localparam int PW = $clog2(FRAME_BITS);

  seq_state_e    state;
  logic [CW-1:0] cnt;
  logic          rise, fall, sdi, alive, tick, frame_end, cold_hold;
  logic [PW-1:0] pos;

  assign cold_hold = ~cold_ctl_i;

  aclink_bclk_mon #(
    .SYNC_STAGES(SYNC_STAGES), .WD_CYC(WD_CYC), .BIT_SYS(BIT_SYS)
  ) u_mon (
    .clk_i, .rst_ni, .bitclk_i, .sdata_i,
    .rise_o(rise), .fall_o(fall), .sdata_o(sdi), .alive_o(alive), .tick_o(tick)
  );

  aclink_frame_pos #(.FRAME_BITS(FRAME_BITS)) u_pos (
    .clk_i, .rst_ni, .hold_i(cold_hold), .rise_i(rise), .alive_i(alive),
    .pos_o(pos), .frame_end_o(frame_end)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state        <= ST_IDLE;
      cnt          <= '0;
      warm_bit_o   <= 1'b0;
      ready_o      <= 1'b0;
      codec_rst_no <= 1'b0;
    end else begin
      codec_rst_no <= cold_ctl_i;
      if (cold_hold) begin
        state      <= ST_IDLE;
        cnt        <= '0;
        warm_bit_o <= 1'b0;
        ready_o    <= 1'b0;
      end else begin
        if (warm_set_i) warm_bit_o <= 1'b1;
        unique case (state)
          ST_IDLE: begin
            if (pdown_i) begin
              state   <= ST_PD_FRAME;
              ready_o <= 1'b0;
            end else begin
              // tag bit is the first bit of the frame
              if (fall && pos == PW'(1)) ready_o <= sdi;
              if (warm_bit_o) begin
                if (!alive) begin
                  state <= ST_SYNC;
                  cnt   <= '0;
                end else begin
                  warm_bit_o <= 1'b0;
                end
              end
            end
          end
          ST_PD_FRAME: begin
            if (frame_end || !alive) begin
              state <= ST_PD_WAIT;
              cnt   <= '0;
            end
          end
          ST_PD_WAIT: begin
            if (tick) begin
              if (cnt == CW'(WAIT_BITS - 1)) state <= ST_IDLE;
              else                           cnt   <= cnt + 1'b1;
            end
          end
          ST_SYNC: begin
            if (cnt == CW'(SYNC_CYC - 1)) begin
              state      <= ST_IDLE;
              warm_bit_o <= 1'b0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign sync_o         = (state == ST_SYNC);
  assign busy_o         = cold_hold | (state != ST_IDLE) | warm_bit_o;
  assign bitclk_alive_o = alive;
endmodule

// File: rtl/aclink_wake_seq_chk.sv
module aclink_wake_seq_chk #(
  parameter int SYNC_CYC = 50
) (
  input logic clk_i,
  input logic rst_ni,
  input logic cold_ctl_i,
  input logic codec_rst_no,
  input logic sync_o,
  input logic warm_bit_o,
  input logic ready_o,
  input logic busy_o,
  input logic bitclk_alive_o
);
  localparam int RW = $clog2(SYNC_CYC + 2);
  logic [RW-1:0] sync_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             sync_run <= '0;
    else if (!sync_o)                        sync_run <= '0;
    else if (sync_run != RW'(SYNC_CYC + 1))  sync_run <= sync_run + 1'b1;
  end

  a_r1_rst_follows_cold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cold_ctl_i |=> !codec_rst_no);

  a_r2_cold_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cold_ctl_i |=> (!warm_bit_o && !ready_o && !sync_o));

  a_r3_sync_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_run <= RW'(SYNC_CYC));

  a_r3_sync_has_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o |-> warm_bit_o);

  a_r4_sync_only_absent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sync_o) |-> !$past(bitclk_alive_o));

  a_r8_busy_covers: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_o || warm_bit_o || !cold_ctl_i) |-> busy_o);
endmodule

bind aclink_wake_seq aclink_wake_seq_chk #(.SYNC_CYC(SYNC_CYC)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cold_ctl_i(cold_ctl_i),
  .codec_rst_no(codec_rst_no), .sync_o(sync_o), .warm_bit_o(warm_bit_o),
  .ready_o(ready_o), .busy_o(busy_o), .bitclk_alive_o(bitclk_alive_o)
);

// File: tb/aclink_wake_seq_test.sv
module aclink_wake_seq_test;
  localparam int SYNC_CYC = 50;
  localparam int WAIT_CYC = 1024 * 4;

  logic clk, rst_n, cold_ctl, warm_set, pdown, bclk, sdi;
  logic codec_rst_n, sync, warm_bit, ready, busy, alive;
  logic bclk_en, tag_val;
  int   bpos;
  int   n_run, n_fail;

  aclink_wake_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .cold_ctl_i(cold_ctl), .warm_set_i(warm_set),
    .pdown_i(pdown), .bitclk_i(bclk), .sdata_i(sdi),
    .codec_rst_no(codec_rst_n), .sync_o(sync), .warm_bit_o(warm_bit),
    .ready_o(ready), .busy_o(busy), .bitclk_alive_o(alive)
  );

  initial begin
    clk = 1'b0;
    forever #2 clk = ~clk;
  end

  // codec model: 16 ns bit clock, tag driven on frame bit 0
  initial begin
    bclk = 1'b0; sdi = 1'b0; bpos = 0;
    forever begin
      #8;
      if (bclk_en) begin
        bclk = ~bclk;
        if (bclk) begin
          sdi  = (bpos == 0) ? tag_val : 1'b0;
          bpos = (bpos + 1) % 256;
        end
      end else begin
        bclk = 1'b0; sdi = 1'b0; bpos = 0;
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic ok, input string req, input string what,
                     input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic pulse_warm();
    warm_set = 1'b1; step(1); warm_set = 1'b0;
  endtask

  task automatic t_reset();
    step(1);
    chk(codec_rst_n == 1'b0, "R1", "codec reset at reset", codec_rst_n, 0);
    chk(sync == 1'b0 && ready == 1'b0, "R2", "sync/ready at reset", {sync, ready}, 0);
    chk(busy == 1'b1, "R8", "busy while cold held", busy, 1);
    chk(alive == 1'b0, "R5", "no bit clock at reset", alive, 0);
    pulse_warm();
    step(1);
    chk(warm_bit == 1'b0, "R2", "warm ignored in cold", warm_bit, 0);
  endtask

  task automatic t_cold_release();
    cold_ctl = 1'b1;
    step(1);
    chk(codec_rst_n == 1'b1, "R1", "codec reset released", codec_rst_n, 1);
    chk(busy == 1'b0, "R8", "idle after release", busy, 0);
  endtask

  task automatic t_warm_absent();
    int hi = 0;
    pulse_warm();
    chk(warm_bit == 1'b1 && busy == 1'b1, "R3", "warm bit set", {warm_bit, busy}, 3);
    for (int i = 0; i < 200; i++) begin
      if (sync) hi++;
      step(1);
    end
    chk(hi == SYNC_CYC, "R3", "sync pulse width", hi, SYNC_CYC);
    chk(warm_bit == 1'b0 && busy == 1'b0, "R3", "warm bit self clears", {warm_bit, busy}, 0);
  endtask

  task automatic t_warm_present();
    int hi = 0;
    tag_val = 1'b1; bclk_en = 1'b1;
    step(20);
    chk(alive == 1'b1, "R5", "bit clock detected", alive, 1);
    pulse_warm();
    for (int i = 0; i < 20; i++) begin
      if (sync) hi++;
      step(1);
    end
    chk(hi == 0, "R4", "no sync with clock present", hi, 0);
    chk(warm_bit == 1'b0, "R4", "warm bit cleared", warm_bit, 0);
  endtask

  task automatic t_ready();
    chk(ready == 1'b1, "R6", "tag 1 sets ready", ready, 1);
    tag_val = 1'b0;
    step(2 * 1024 + 40);
    chk(ready == 1'b0, "R6", "tag 0 clears ready", ready, 0);
    tag_val = 1'b1;
    step(1024 + 40);
    chk(ready == 1'b1, "R6", "tag 1 sets ready again", ready, 1);
  endtask

  task automatic t_powerdown();
    int n = 0, bad = 0, hi = 0;
    pdown = 1'b1; step(1); pdown = 1'b0;
    chk(ready == 1'b0 && busy == 1'b1, "R7", "power-down clears ready", {ready, busy}, 1);
    pulse_warm();
    while (bpos != 0) step(1);
    bclk_en = 1'b0;
    while (!sync && n < 6000) begin
      if (!busy || !warm_bit) bad++;
      step(1);
      n++;
    end
    chk(n >= WAIT_CYC && n <= WAIT_CYC + 200, "R7", "cycles from frame end to sync", n, WAIT_CYC);
    chk(bad == 0, "R8", "busy and pending warm held in wait", bad, 0);
    for (int i = 0; i < 100; i++) begin
      if (sync) hi++;
      step(1);
    end
    chk(hi == SYNC_CYC - 1 + 1, "R3", "wake pulse width", hi, SYNC_CYC);
    chk(busy == 1'b0 && warm_bit == 1'b0, "R8", "idle after wake", {busy, warm_bit}, 0);
    bclk_en = 1'b1;
    step(60);
    chk(ready == 1'b1, "R6", "ready from restarted frame", ready, 1);
  endtask

  task automatic t_cold_abort();
    int hi = 0;
    pdown = 1'b1; step(1); pdown = 1'b0;
    pulse_warm();
    bclk_en = 1'b0;
    step(100);
    cold_ctl = 1'b0;
    step(2);
    chk(codec_rst_n == 1'b0 && busy == 1'b1, "R1", "cold mid-wait", {codec_rst_n, busy}, 1);
    chk(warm_bit == 1'b0 && ready == 1'b0, "R2", "cold discards request", {warm_bit, ready}, 0);
    cold_ctl = 1'b1;
    step(1);
    chk(busy == 1'b0, "R2", "no sequence after release", busy, 0);
    for (int i = 0; i < 100; i++) begin
      if (sync) hi++;
      step(1);
    end
    chk(hi == 0, "R2", "no sync replayed", hi, 0);
  endtask

  task automatic t_watchdog();
    bclk_en = 1'b1;
    step(40);
    bclk_en = 1'b0;
    step(8);
    chk(alive == 1'b1, "R5", "alive inside watchdog window", alive, 1);
    step(32);
    chk(alive == 1'b0, "R5", "absent after watchdog", alive, 0);
  endtask

  initial begin
    #(4 * 150000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    n_run = 0; n_fail = 0;
    rst_n = 1'b0; cold_ctl = 1'b0; warm_set = 1'b0; pdown = 1'b0;
    bclk_en = 1'b0; tag_val = 1'b0;
    step(3);
    rst_n = 1'b1;
    t_reset();
    t_cold_release();
    t_warm_absent();
    t_warm_present();
    t_ready();
    t_powerdown();
    t_cold_abort();
    t_watchdog();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule